// File: doc/BRIEF.md
# Programmable Video Output Timing Generator

This block drives the timing side of a video output. From programmable values it produces horizontal sync, vertical sync and a data-enable strobe, plus the column and row index of the pixel in the visible window. A line is laid out as sync pulse, back porch, visible pixels and then front porch. A frame uses the same order, counted in lines.

Each of the three strobes has its own polarity bit. A frame-period target, counted in pixel clocks, can hold the frame rate at a fixed value. The generator makes the front porch of the final line of each frame longer, so that this one line is longer than the others and the whole frame lasts exactly the target. If the target is not above the nominal frame length, no stretch is applied.

Configuration ports are captured only on the last clock of a frame, so a new setting never tears a frame. Parameters give the settings used for the first frame after reset.

Top module: `vidTimingGen`

## Requirements
- R1: During reset, hSyncOut, vSyncOut and deOut sit at their inactive levels for the reset polarities, and pixX and pixY are 0. The first frame after reset uses the parameter defaults: 1280 x 640 visible, hsync 40, horizontal back porch 50, horizontal front porch 50, vsync 20 lines, vertical back porch 31, vertical front porch 30, hsync and vsync active low, DE active high, frame target 0.
- R2: Every line starts with hSyncLen clocks of hsync. These are followed by hBackLen porch clocks, actWidth visible clocks and hFrontLen porch clocks, so the nominal line is the sum of the four.
- R3: vsync is active for every clock of the first vSyncLen lines of a frame. These are followed by vBackLen porch lines, actHeight visible lines and vFrontLen porch lines.
- R4: deOut is active only on clocks that are in the visible part of both the line and the frame. hsync and DE are never active on the same clock.
- R5: A polarity input of 1 makes that output active high, and 0 makes it active low. Each of hSyncHigh, vSyncHigh and deHigh acts only on its own output.
- R6: While DE is active, pixX runs 0 to actWidth-1 along the line and pixY runs 0 to actHeight-1 down the frame. Both are 0 whenever DE is inactive.
- R7: When frameTarget is greater than the nominal frame length (line total x line count), the front porch of the last line grows by the difference, so the frame lasts exactly frameTarget clocks.
- R8: When frameTarget is not greater than the nominal frame length, the stretch is zero and the frame lasts the nominal length.
- R9: Configuration inputs are sampled only on the final clock of a frame. A change made during a frame first affects the next frame.
- R10: Outputs are registered. The first clock edge after reset release presents line 0, clock 0 of the first frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| actWidth | input | 12 | Visible pixels per line |
| actHeight | input | 12 | Visible lines per frame |
| hSyncLen | input | 12 | Hsync pulse width in clocks |
| hBackLen | input | 12 | Clocks between hsync end and first visible pixel |
| hFrontLen | input | 12 | Clocks after last visible pixel before next hsync |
| vSyncLen | input | 12 | Vsync pulse width in lines |
| vBackLen | input | 12 | Lines between vsync end and first visible line |
| vFrontLen | input | 12 | Lines after last visible line before next vsync |
| hSyncHigh | input | 1 | 1 = hsync active high |
| vSyncHigh | input | 1 | 1 = vsync active high |
| deHigh | input | 1 | 1 = DE active high |
| frameTarget | input | 24 | Frame period target in clocks, 0 or small = no limit |
| hSyncOut | output | 1 | Horizontal sync |
| vSyncOut | output | 1 | Vertical sync |
| deOut | output | 1 | Data enable |
| pixX | output | 12 | Column of visible pixel, 0 outside DE |
| pixY | output | 12 | Row of visible pixel, 0 outside DE |

## Verification
The assertions check on every clock that hsync and DE are never active together, that pixel indices stay inside the visible window and step by one along a line, that the indices are zero outside DE, and that the captured configuration changes only after a frame-end strobe. What only the bench scenarios can show are whole-frame results. These are the exact frame period with and without the stretch, a setting changed mid-frame taking effect one frame later, and the active levels after a polarity flip. A clock-by-clock reference model also tracks every strobe and index across several configuration changes.

// File: rtl/vtgPkg.sv
package vtgPkg;
  localparam int DIM_W  = 12;
  localparam int CNT_W  = 24;
  localparam int WIDE_W = 2 * CNT_W;

  typedef logic [DIM_W-1:0] dim_t;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    dim_t actW;
    dim_t actH;
    dim_t hSync;
    dim_t hBack;
    dim_t hFront;
    dim_t vSync;
    dim_t vBack;
    dim_t vFront;
    logic hPol;
    logic vPol;
    logic dePol;
    cnt_t frameTarget;
  } cfg_t;

  // strobes from the counter control to the output datapath
  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
    logic frameEnd;
    dim_t xPos;
    dim_t yPos;
  } strobe_t;

  function automatic cnt_t lineTotal(cfg_t c);
    return cnt_t'(c.hSync) + cnt_t'(c.hBack) + cnt_t'(c.actW) + cnt_t'(c.hFront);
  endfunction

  function automatic cnt_t frameLines(cfg_t c);
    return cnt_t'(c.vSync) + cnt_t'(c.vBack) + cnt_t'(c.actH) + cnt_t'(c.vFront);
  endfunction

  // clocks added to the last line so the frame meets its target
  function automatic cnt_t stretchOf(cfg_t c);
    logic [WIDE_W-1:0] nominal;
    logic [WIDE_W-1:0] target;
    nominal = WIDE_W'(lineTotal(c)) * WIDE_W'(frameLines(c));
    target  = WIDE_W'(c.frameTarget);
    return (target > nominal) ? cnt_t'(target - nominal) : '0;
  endfunction
endpackage

// File: rtl/vtgCtrl.sv
module vtgCtrl
  import vtgPkg::*;
#(
  parameter cfg_t RST_CFG = '0
) (
  input  logic    clk,
  input  logic    rstN,
  input  cfg_t    cfgIn,
  output cfg_t    cfgNow,
  output strobe_t stb
);
  cnt_t hCnt, vCnt, stretch;
  cnt_t hTot, vTot, hActLo, hActHi, vActLo, vActHi, lineLen;
  logic lastLine, lineEnd, hAct, vAct;

  always_comb begin
    hTot     = lineTotal(cfgNow);
    vTot     = frameLines(cfgNow);
    hActLo   = cnt_t'(cfgNow.hSync) + cnt_t'(cfgNow.hBack);
    hActHi   = hActLo + cnt_t'(cfgNow.actW);
    vActLo   = cnt_t'(cfgNow.vSync) + cnt_t'(cfgNow.vBack);
    vActHi   = vActLo + cnt_t'(cfgNow.actH);
    lastLine = (vCnt == vTot - 1'b1);
    lineLen  = hTot + (lastLine ? stretch : '0);
    lineEnd  = (hCnt == lineLen - 1'b1);
    hAct     = (hCnt >= hActLo) && (hCnt < hActHi);
    vAct     = (vCnt >= vActLo) && (vCnt < vActHi);

    stb.hs       = hCnt < cnt_t'(cfgNow.hSync);
    stb.vs       = vCnt < cnt_t'(cfgNow.vSync);
    stb.de       = hAct && vAct;
    stb.frameEnd = lineEnd && lastLine;
    stb.xPos     = dim_t'(hCnt - hActLo);
    stb.yPos     = dim_t'(vCnt - vActLo);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt    <= '0;
      vCnt    <= '0;
      cfgNow  <= RST_CFG;
      stretch <= stretchOf(RST_CFG);
    end else if (stb.frameEnd) begin
      hCnt    <= '0;
      vCnt    <= '0;
      cfgNow  <= cfgIn;
      stretch <= stretchOf(cfgIn);
    end else if (lineEnd) begin
      hCnt <= '0;
      vCnt <= vCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end
endmodule

// File: rtl/vtgData.sv
module vtgData
  import vtgPkg::*;
#(
  parameter logic [2:0] RST_POL = 3'b100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] lvl,
  input  logic [2:0] pol,
  input  logic       act,
  input  dim_t       xPos,
  input  dim_t       yPos,
  output logic [2:0] syncOut,
  output dim_t       pixX,
  output dim_t       pixY
);
  // one registered driver per strobe: bit 0 hsync, 1 vsync, 2 DE
  for (genvar i = 0; i < 3; i++) begin : g_sync
    logic q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= ~RST_POL[i];
      else       q <= ~(lvl[i] ^ pol[i]);
    end
    assign syncOut[i] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixX <= '0;
      pixY <= '0;
    end else begin
      pixX <= act ? xPos : '0;
      pixY <= act ? yPos : '0;
    end
  end
endmodule

// File: rtl/vidTimingGen.sv
module vidTimingGen
  import vtgPkg::*;
#(
  parameter int DEF_ACT_W  = 1280,
  parameter int DEF_ACT_H  = 640,
  parameter int DEF_HSYNC  = 40,
  parameter int DEF_HBACK  = 50,
  parameter int DEF_HFRONT = 50,
  parameter int DEF_VSYNC  = 20,
  parameter int DEF_VBACK  = 31,
  parameter int DEF_VFRONT = 30,
  parameter bit DEF_HPOL   = 1'b0,
  parameter bit DEF_VPOL   = 1'b0,
  parameter bit DEF_DEPOL  = 1'b1,
  parameter int DEF_TARGET = 0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [vtgPkg::DIM_W-1:0]    actWidth,
  input  logic [vtgPkg::DIM_W-1:0]    actHeight,
  input  logic [vtgPkg::DIM_W-1:0]    hSyncLen,
  input  logic [vtgPkg::DIM_W-1:0]    hBackLen,
  input  logic [vtgPkg::DIM_W-1:0]    hFrontLen,
  input  logic [vtgPkg::DIM_W-1:0]    vSyncLen,
  input  logic [vtgPkg::DIM_W-1:0]    vBackLen,
  input  logic [vtgPkg::DIM_W-1:0]    vFrontLen,
  input  logic                        hSyncHigh,
  input  logic                        vSyncHigh,
  input  logic                        deHigh,
  input  logic [vtgPkg::CNT_W-1:0]    frameTarget,
  output logic                        hSyncOut,
  output logic                        vSyncOut,
  output logic                        deOut,
  output logic [vtgPkg::DIM_W-1:0]    pixX,
  output logic [vtgPkg::DIM_W-1:0]    pixY
);
  localparam cfg_t RST_CFG = '{
    actW: dim_t'(DEF_ACT_W),   actH: dim_t'(DEF_ACT_H),
    hSync: dim_t'(DEF_HSYNC),  hBack: dim_t'(DEF_HBACK),
    hFront: dim_t'(DEF_HFRONT),
    vSync: dim_t'(DEF_VSYNC),  vBack: dim_t'(DEF_VBACK),
    vFront: dim_t'(DEF_VFRONT),
    hPol: DEF_HPOL, vPol: DEF_VPOL, dePol: DEF_DEPOL,
    frameTarget: cnt_t'(DEF_TARGET)
  };
  localparam logic [2:0] RST_POL = {DEF_DEPOL, DEF_VPOL, DEF_HPOL};

  cfg_t       cfgIn;
  cfg_t       cfgNow;
  strobe_t    stb;
  logic [2:0] syncVec;

  assign cfgIn = '{
    actW: actWidth, actH: actHeight,
    hSync: hSyncLen, hBack: hBackLen, hFront: hFrontLen,
    vSync: vSyncLen, vBack: vBackLen, vFront: vFrontLen,
    hPol: hSyncHigh, vPol: vSyncHigh, dePol: deHigh,
    frameTarget: frameTarget
  };

  vtgCtrl #(.RST_CFG(RST_CFG)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cfgIn  (cfgIn),
    .cfgNow (cfgNow),
    .stb    (stb)
  );

  vtgData #(.RST_POL(RST_POL)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .lvl     ({stb.de, stb.vs, stb.hs}),
    .pol     ({cfgNow.dePol, cfgNow.vPol, cfgNow.hPol}),
    .act     (stb.de),
    .xPos    (stb.xPos),
    .yPos    (stb.yPos),
    .syncOut (syncVec),
    .pixX    (pixX),
    .pixY    (pixY)
  );

  assign hSyncOut = syncVec[0];
  assign vSyncOut = syncVec[1];
  assign deOut    = syncVec[2];
endmodule

// File: rtl/vtgChecker.sv
module vtgChecker
  import vtgPkg::*;
(
  input logic    clk,
  input logic    rstN,
  input strobe_t stb,
  input cfg_t    cfgNow,
  input dim_t    pixX,
  input dim_t    pixY
);
  // R4
  hsync_de_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.hs && stb.de));

  // R6
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.de |-> (stb.xPos < cfgNow.actW) && (stb.yPos < cfgNow.actH));

  // R6
  pix_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.de |=> (pixX == '0) && (pixY == '0));

  // R6
  xpos_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.de && $past(stb.de) && stb.xPos != '0) |-> stb.xPos == $past(stb.xPos) + 1'b1);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.frameEnd |=> $stable(cfgNow));
endmodule

bind vidTimingGen vtgChecker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .stb    (stb),
  .cfgNow (cfgNow),
  .pixX   (pixX),
  .pixY   (pixY)
);

// File: tb/vidTimingGen_tb.sv
`timescale 1ns/1ps
module vidTimingGen_tb;
  // small reset defaults so frames stay short: line 15, frame 8 lines, 120 clocks
  localparam int DW = 8, DH = 4, DHS = 2, DHB = 3, DHF = 2, DVS = 1, DVB = 2, DVF = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] actWidth, actHeight, hSyncLen, hBackLen, hFrontLen;
  logic [11:0] vSyncLen, vBackLen, vFrontLen;
  logic hSyncHigh, vSyncHigh, deHigh;
  logic [23:0] frameTarget;
  logic hSyncOut, vSyncOut, deOut;
  logic [11:0] pixX, pixY;

  int checks = 0, errors = 0;
  bit started = 0, done = 0;

  always #2.5 clk = ~clk;

  vidTimingGen #(
    .DEF_ACT_W(DW), .DEF_ACT_H(DH), .DEF_HSYNC(DHS), .DEF_HBACK(DHB),
    .DEF_HFRONT(DHF), .DEF_VSYNC(DVS), .DEF_VBACK(DVB), .DEF_VFRONT(DVF)
  ) u_dut (
    .clk(clk), .rstN(rstN), .actWidth(actWidth), .actHeight(actHeight),
    .hSyncLen(hSyncLen), .hBackLen(hBackLen), .hFrontLen(hFrontLen),
    .vSyncLen(vSyncLen), .vBackLen(vBackLen), .vFrontLen(vFrontLen),
    .hSyncHigh(hSyncHigh), .vSyncHigh(vSyncHigh), .deHigh(deHigh),
    .frameTarget(frameTarget), .hSyncOut(hSyncOut), .vSyncOut(vSyncOut),
    .deOut(deOut), .pixX(pixX), .pixY(pixY)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mw, mh, mhs, mhb, mhf, mvs, mvb, mvf, mhp, mvp, mdp, mtg, mExtra, hc, vc;
  int eH, eV, eDe, eX, eY;

  function automatic int clipStretch(int tg, int lineN, int lines);
    return (tg > lineN * lines) ? tg - lineN * lines : 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mw = DW; mh = DH; mhs = DHS; mhb = DHB; mhf = DHF;
      mvs = DVS; mvb = DVB; mvf = DVF; mhp = 0; mvp = 0; mdp = 1; mtg = 0;
      mExtra = 0; hc = 0; vc = 0;
      eH = 1; eV = 1; eDe = 0; eX = 0; eY = 0;
    end else begin
      int lineN, lines, len;
      bit ha, va;
      lineN = mhs + mhb + mw + mhf;
      lines = mvs + mvb + mh + mvf;
      ha = (hc >= mhs + mhb) && (hc < mhs + mhb + mw);
      va = (vc >= mvs + mvb) && (vc < mvs + mvb + mh);
      eH  = (hc < mhs) ? mhp : 1 - mhp;
      eV  = (vc < mvs) ? mvp : 1 - mvp;
      eDe = (ha && va) ? mdp : 1 - mdp;
      eX  = (ha && va) ? hc - mhs - mhb : 0;
      eY  = (ha && va) ? vc - mvs - mvb : 0;
      len = lineN + ((vc == lines - 1) ? mExtra : 0);
      if (hc == len - 1) begin
        hc = 0;
        if (vc == lines - 1) begin
          vc = 0;
          mw = actWidth; mh = actHeight; mhs = hSyncLen; mhb = hBackLen;
          mhf = hFrontLen; mvs = vSyncLen; mvb = vBackLen; mvf = vFrontLen;
          mhp = hSyncHigh; mvp = vSyncHigh; mdp = deHigh; mtg = frameTarget;
          mExtra = clipStretch(mtg, mhs + mhb + mw + mhf, mvs + mvb + mh + mvf);
        end else vc++;
      end else hc++;
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && rstN && !done) begin
      check(hSyncOut == eH[0], "R2 hsync", hSyncOut, eH);
      check(vSyncOut == eV[0], "R3 vsync", vSyncOut, eV);
      check(deOut == eDe[0], "R4 de", deOut, eDe);
      check(pixX == eX && pixY == eY, "R6 pixel index", pixX * 4096 + pixY, eX * 4096 + eY);
    end
  end

  // frame starts at the clock where active-low vsync falls
  task automatic waitStart();
    logic prev;
    prev = vSyncOut;
    @(negedge clk);
    while (!(prev && !vSyncOut)) begin
      prev = vSyncOut;
      @(negedge clk);
    end
  endtask

  task automatic framePeriod(output int p);
    logic prev;
    p = 0;
    do begin
      prev = vSyncOut;
      @(negedge clk);
      p++;
    end while (!(prev && !vSyncOut));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int p, cDe, cH, cV;
    // config A: line 12, 8 lines, 96 clocks
    actWidth = 6; actHeight = 3; hSyncLen = 1; hBackLen = 2; hFrontLen = 3;
    vSyncLen = 2; vBackLen = 1; vFrontLen = 2;
    hSyncHigh = 0; vSyncHigh = 0; deHigh = 1; frameTarget = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset levels
    check(hSyncOut == 1 && vSyncOut == 1 && deOut == 0 && pixX == 0 && pixY == 0,
          "R1 reset outputs", {hSyncOut, vSyncOut, deOut}, 3'b110);
    rstN = 1'b1;
    // R10 first edge shows frame start
    waitStart();
    check(hSyncOut == 0 && vSyncOut == 0, "R10 first edge", {hSyncOut, vSyncOut}, 0);
    framePeriod(p);
    check(p == 120, "R1 default frame period", p, 120);
    framePeriod(p);
    check(p == 96, "R2 R3 nominal frame period", p, 96);
    frameTarget = 150;
    framePeriod(p);
    check(p == 96, "R9 mid-frame change deferred", p, 96);
    framePeriod(p);
    check(p == 150, "R7 stretched frame period", p, 150);
    frameTarget = 50;
    framePeriod(p);
    check(p == 150, "R9 stretch held for frame", p, 150);
    framePeriod(p);
    check(p == 96, "R8 target below nominal", p, 96);
    hSyncHigh = 1; vSyncHigh = 1; deHigh = 0;
    repeat (96) @(negedge clk);
    cDe = 0; cH = 0; cV = 0;
    for (int i = 0; i < 96; i++) begin
      if (i != 0) @(negedge clk);
      cDe += (deOut == 0);
      cH  += (hSyncOut == 1);
      cV  += (vSyncOut == 1);
    end
    check(cDe == 18, "R5 de active low count", cDe, 18);
    check(cH == 8, "R5 hsync active high count", cH, 8);
    check(cV == 24, "R5 vsync active high count", cV, 24);
    repeat (20) @(negedge clk);
    finishRun();
  end
endmodule